// File: doc/BRIEF.md
# Loopback test function controller

This block is a memory-mapped test function that a host uses to check an endpoint link. The host programs a small register file over a simple slave bus. The registers hold a scratch word, buffer addresses, a transfer length in bytes and a checksum. The host then writes a command word. The command starts one action, which is a read of host memory, a write of a generated pattern into host memory, or a word-by-word copy from one host buffer to another. All transfers use a master memory port with a valid/ready handshake, and the response returns one cycle after each accepted request.

When the action ends, the block records success or failure for that operation in a status register. It records invalid source or destination addresses in the same register. If the command asks for it, the block then pulses either a legacy interrupt line or an MSI request that carries a vector taken from the command. Only one action runs at a time. The command register reads nonzero while an action is running and clears itself when the action ends, so the host can poll it.

Top module: `lbt_top`

## Requirements
- R1: After reset, every register reads zero, and memReq, irqLegacy and msiReq are low.
- R2: regAddr selects a register by word index: 0 is scratch, 1 is command, 2 is status, 3 is source address, 4 is destination address, 5 is size in bytes, and 6 is checksum. The scratch register reads back whatever was last written to it. Writes to status have no effect.
- R3: Command bit 8 requests a read, bit 9 a write and bit 10 a copy. If more than one of these bits is set, read wins over write and write wins over copy. A command with none of these bits performs no transfer.
- R4: A write stores ceil(size/4) words at the destination address plus 4k. Word k holds the scratch value XOR k. The checksum register then holds the XOR of all words written, and status bit 2 is set.
- R5: A read fetches ceil(size/4) words from the source address. If their XOR equals the checksum register, status bit 0 is set. Otherwise status bit 1 is set.
- R6: A copy moves ceil(size/4) words from the source buffer to the destination buffer in ascending order and then sets status bit 4.
- R7: A size of zero sets the operation's success bit (bit 0, 2 or 4) without any memory access and without checking the addresses.
- R8: A used address is invalid if it is not 4-byte aligned, or if the buffer [addr, addr+ceil(size/4)*4) does not lie inside [WIN_BASE, WIN_BASE+WIN_BYTES). An invalid source sets status bit 7, an invalid destination sets bit 8, and either also sets the fail bit (1, 3 or 5). No memory access is made in that case.
- R9: An error response (memRspErr with memRspValid) sets the operation's fail bit and stops the action. No further request is issued.
- R10: When the action ends, command bit 1 produces a single one-cycle msiReq pulse with msiVec equal to command bits 7:2. Otherwise command bit 0 produces a single one-cycle irqLegacy pulse. Status bit 6 reads 1 from the cycle of that pulse onward.
- R11: Accepting a command clears the status register. The command register reads zero again once the action ends.
- R12: While an action runs, writes to the command, source, destination, size and checksum registers are ignored.
- R13: A request on the master port keeps memReq, memAddr and memWdata steady until the cycle in which memGnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| memReq | output | 1 | Master request valid |
| memWe | output | 1 | Master request is a write |
| memAddr | output | 32 | Master byte address |
| memWdata | output | 32 | Master write data |
| memGnt | input | 1 | Master request accepted (ready) |
| memRspValid | input | 1 | Response valid, one cycle after acceptance |
| memRspData | input | 32 | Read response data |
| memRspErr | input | 1 | Error response |
| irqLegacy | output | 1 | Legacy interrupt pulse |
| msiReq | output | 1 | MSI request pulse |
| msiVec | output | 6 | MSI vector, valid with msiReq |

## Verification
A new command write can arrive in the same cycle in which the running action finishes and clears its own command register. The bench provokes this collision by polling the command register during a long copy and writing a conflicting command in every cycle in which it still reads nonzero. Because the poll stops as soon as the register reads zero, the last of those writes falls exactly on the completion cycle. The bench judges the result in three ways. The status must show only the copy's own outcome. Exactly one interrupt of the copy's kind must have occurred. The command register must read zero afterwards.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 3;
  localparam int VEC_W  = 6;
  localparam int CMD_W  = 11;
  localparam int STS_W  = 9;

  localparam logic [IDX_W-1:0] REG_MAGIC = 3'd0;
  localparam logic [IDX_W-1:0] REG_CMD   = 3'd1;
  localparam logic [IDX_W-1:0] REG_STS   = 3'd2;
  localparam logic [IDX_W-1:0] REG_SRC   = 3'd3;
  localparam logic [IDX_W-1:0] REG_DST   = 3'd4;
  localparam logic [IDX_W-1:0] REG_SIZE  = 3'd5;
  localparam logic [IDX_W-1:0] REG_CSUM  = 3'd6;

  localparam int CMD_LEGACY = 0;
  localparam int CMD_MSI    = 1;
  localparam int CMD_VEC_LO = 2;
  localparam int CMD_RD     = 8;
  localparam int CMD_WR     = 9;
  localparam int CMD_CP     = 10;

  localparam int STS_IRQ     = 6;
  localparam int STS_BAD_SRC = 7;
  localparam int STS_BAD_DST = 8;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_COPY} op_e;

  typedef struct packed {
    logic             clrStatus;
    logic [STS_W-1:0] setSts;
    logic             ldCsum;
    logic             accClr;
    logic             accEn;
    logic             accSelW;
    logic             bufLd;
    logic             cntClr;
    logic             cntInc;
    logic             selDst;
    logic             finish;
  } strobe_t;

  typedef struct packed {
    logic start;
    op_e  op;
    logic sizeZero;
    logic srcBad;
    logic dstBad;
    logic lastWord;
    logic sumMatch;
  } info_t;
endpackage

// File: rtl/lbt_dpath.sv
module lbt_dpath
  import lbt_pkg::*;
#(
  parameter logic [WORD_W-1:0] WIN_BASE  = 32'h0001_0000,
  parameter logic [WORD_W-1:0] WIN_BYTES = 32'h0000_4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              busy,
  input  strobe_t           stb,
  output info_t             info,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRspData,
  output logic              irqLegacy,
  output logic              msiReq,
  output logic [VEC_W-1:0]  msiVec
);
  localparam logic [WORD_W:0] WIN_END = {1'b0, WIN_BASE} + {1'b0, WIN_BYTES};

  logic [WORD_W-1:0] magicQ, srcQ, dstQ, sizeQ, csumQ, accQ, bufQ, offQ;
  logic [CMD_W-1:0]  cmdQ;
  logic [STS_W-1:0]  stsQ;
  logic              legQ, msiQ;
  logic [VEC_W-1:0]  vecQ;
  logic [WORD_W:0]   sizeRnd;
  logic [WORD_W-1:0] accNext;
  logic              cmdWr, cfgOk, wantMsi, wantLeg;
  op_e               op;

  assign cmdWr   = regWrEn && (regAddr == REG_CMD);
  assign cfgOk   = regWrEn && !busy;
  assign sizeRnd = ({1'b0, sizeQ} + 33'd3) & ~33'd3;
  assign wantMsi = cmdQ[CMD_MSI];
  assign wantLeg = cmdQ[CMD_LEGACY] && !cmdQ[CMD_MSI];

  function automatic logic addrOk(input logic [WORD_W-1:0] a);
    logic [WORD_W:0] endA;
    endA = {1'b0, a} + sizeRnd;
    return (a[1:0] == 2'b00) && (a >= WIN_BASE) && (endA <= WIN_END);
  endfunction

  always_comb begin
    if (cmdQ[CMD_RD])      op = OP_READ;
    else if (cmdQ[CMD_WR]) op = OP_WRITE;
    else if (cmdQ[CMD_CP]) op = OP_COPY;
    else                   op = OP_NONE;
  end

  assign memAddr  = (stb.selDst ? dstQ : srcQ) + offQ;
  assign memWdata = (op == OP_COPY) ? bufQ : (magicQ ^ {2'b00, offQ[WORD_W-1:2]});
  assign accNext  = accQ ^ (stb.accSelW ? memWdata : memRspData);

  always_comb begin
    info.start    = cmdWr && !busy;
    info.op       = op;
    info.sizeZero = (sizeQ == '0);
    info.srcBad   = !addrOk(srcQ);
    info.dstBad   = !addrOk(dstQ);
    info.lastWord = ({1'b0, offQ} + 33'd4) >= sizeRnd;
    info.sumMatch = ((accQ ^ memRspData) == csumQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magicQ <= '0; srcQ <= '0; dstQ <= '0; sizeQ <= '0; csumQ <= '0;
      cmdQ   <= '0;
    end else begin
      if (regWrEn && regAddr == REG_MAGIC) magicQ <= regWrData;
      if (cfgOk && regAddr == REG_SRC)     srcQ   <= regWrData;
      if (cfgOk && regAddr == REG_DST)     dstQ   <= regWrData;
      if (cfgOk && regAddr == REG_SIZE)    sizeQ  <= regWrData;
      if (stb.ldCsum)                      csumQ  <= accNext;
      else if (cfgOk && regAddr == REG_CSUM) csumQ <= regWrData;
      if (stb.finish)                      cmdQ   <= '0;
      else if (cfgOk && regAddr == REG_CMD) cmdQ  <= regWrData[CMD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0; bufQ <= '0; offQ <= '0; stsQ <= '0;
      legQ <= 1'b0; msiQ <= 1'b0; vecQ <= '0;
    end else begin
      if (stb.accClr)      accQ <= '0;
      else if (stb.accEn)  accQ <= accNext;
      if (stb.bufLd)       bufQ <= memRspData;
      if (stb.cntClr)      offQ <= '0;
      else if (stb.cntInc) offQ <= offQ + 32'd4;
      if (stb.clrStatus)   stsQ <= '0;
      else begin
        stsQ <= stsQ | stb.setSts;
        if (stb.finish && (wantMsi || wantLeg)) stsQ[STS_IRQ] <= 1'b1;
      end
      legQ <= stb.finish && wantLeg;
      msiQ <= stb.finish && wantMsi;
      if (stb.finish && wantMsi) vecQ <= cmdQ[CMD_VEC_LO +: VEC_W];
    end
  end

  assign irqLegacy = legQ;
  assign msiReq    = msiQ;
  assign msiVec    = vecQ;

  always_comb begin
    case (regAddr)
      REG_MAGIC: regRdData = magicQ;
      REG_CMD:   regRdData = {{(WORD_W-CMD_W){1'b0}}, cmdQ};
      REG_STS:   regRdData = {{(WORD_W-STS_W){1'b0}}, stsQ};
      REG_SRC:   regRdData = srcQ;
      REG_DST:   regRdData = dstQ;
      REG_SIZE:  regRdData = sizeQ;
      REG_CSUM:  regRdData = csumQ;
      default:   regRdData = '0;
    endcase
  end

  // R10
  irq_sts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (legQ || msiQ) |-> stsQ[STS_IRQ]);
  // R10
  irq_one_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({legQ, msiQ}));
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (legQ || msiQ) |=> !(legQ || msiQ));
  // R12
  cmd_busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWr && !stb.finish) |=> (cmdQ == $past(cmdQ)));
  // R4
  ok_fail_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stsQ[0] && stsQ[1]) && !(stsQ[2] && stsQ[3]) && !(stsQ[4] && stsQ[5]));
endmodule

// File: rtl/lbt_ctrl.sv
module lbt_ctrl
  import lbt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  info_t   info,
  input  logic    memGnt,
  input  logic    memRspValid,
  input  logic    memRspErr,
  output strobe_t stb,
  output logic    busy,
  output logic    memReq,
  output logic    memWe
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_DONE} state_e;
  state_e state, nextState;

  int  okBit;
  logic needSrc, needDst;

  always_comb begin
    case (info.op)
      OP_READ:  okBit = 0;
      OP_WRITE: okBit = 2;
      default:  okBit = 4;
    endcase
    needSrc = (info.op == OP_READ)  || (info.op == OP_COPY);
    needDst = (info.op == OP_WRITE) || (info.op == OP_COPY);
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      S_IDLE: if (info.start) begin
        stb.clrStatus = 1'b1;
        nextState     = S_START;
      end
      S_START: begin
        stb.accClr = 1'b1;
        stb.cntClr = 1'b1;
        if (info.op == OP_NONE) nextState = S_DONE;
        else if (info.sizeZero) begin
          stb.setSts[okBit] = 1'b1;
          nextState = S_DONE;
        end else if ((needSrc && info.srcBad) || (needDst && info.dstBad)) begin
          stb.setSts[okBit+1]      = 1'b1;
          stb.setSts[STS_BAD_SRC]  = needSrc && info.srcBad;
          stb.setSts[STS_BAD_DST]  = needDst && info.dstBad;
          nextState = S_DONE;
        end else nextState = (info.op == OP_WRITE) ? S_WR_REQ : S_RD_REQ;
      end
      S_RD_REQ: begin
        memReq = 1'b1;
        if (memGnt) nextState = S_RD_WAIT;
      end
      S_RD_WAIT: if (memRspValid) begin
        if (memRspErr) begin
          stb.setSts[okBit+1] = 1'b1;
          nextState = S_DONE;
        end else if (info.op == OP_COPY) begin
          stb.bufLd = 1'b1;
          nextState = S_WR_REQ;
        end else begin
          stb.accEn = 1'b1;
          if (info.lastWord) begin
            stb.setSts[info.sumMatch ? 0 : 1] = 1'b1;
            nextState = S_DONE;
          end else begin
            stb.cntInc = 1'b1;
            nextState  = S_RD_REQ;
          end
        end
      end
      S_WR_REQ: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        stb.selDst = 1'b1;
        if (memGnt) nextState = S_WR_WAIT;
      end
      S_WR_WAIT: begin
        stb.selDst = 1'b1;
        if (memRspValid) begin
          if (memRspErr) begin
            stb.setSts[okBit+1] = 1'b1;
            nextState = S_DONE;
          end else begin
            stb.accEn   = (info.op == OP_WRITE);
            stb.accSelW = 1'b1;
            if (info.lastWord) begin
              stb.setSts[okBit] = 1'b1;
              stb.ldCsum        = (info.op == OP_WRITE);
              nextState         = S_DONE;
            end else begin
              stb.cntInc = 1'b1;
              nextState  = (info.op == OP_COPY) ? S_RD_REQ : S_WR_REQ;
            end
          end
        end
      end
      S_DONE: begin
        stb.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != S_IDLE);

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memWe)));
  // R8
  no_req_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    info.start && !busy |=> !memReq);
endmodule

// File: rtl/lbt_top.sv
module lbt_top
  import lbt_pkg::*;
#(
  parameter logic [31:0] WIN_BASE  = 32'h0001_0000,
  parameter logic [31:0] WIN_BYTES = 32'h0000_4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memGnt,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  input  logic        memRspErr,
  output logic        irqLegacy,
  output logic        msiReq,
  output logic [5:0]  msiVec
);
  strobe_t stb;
  info_t   info;
  logic    busy;

  lbt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .info(info), .memGnt(memGnt),
    .memRspValid(memRspValid), .memRspErr(memRspErr),
    .stb(stb), .busy(busy), .memReq(memReq), .memWe(memWe)
  );

  lbt_dpath #(.WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) i_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .stb(stb),
    .info(info), .memAddr(memAddr), .memWdata(memWdata), .memRspData(memRspData),
    .irqLegacy(irqLegacy), .msiReq(msiReq), .msiVec(msiVec)
  );

  // R13
  req_payload_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> ($stable(memAddr) && $stable(memWdata)));
endmodule

// File: tb/test_lbt_top.sv
`timescale 1ns/1ps
module test_lbt_top;
  localparam logic [31:0] WBASE  = 32'h0001_0000;
  localparam logic [31:0] WBYTES = 32'h0000_4000;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        memReq, memWe, memGnt = 1'b0, memRspValid = 1'b0, memRspErr = 1'b0;
  logic [31:0] memAddr, memWdata, memRspData = '0;
  logic        irqLegacy, msiReq;
  logic [5:0]  msiVec;

  logic [31:0] mem [0:4095];
  int total = 0, bad = 0, legCnt = 0, msiCnt = 0, accCnt = 0;
  logic [5:0]  lastVec = '0;
  logic        errEn = 1'b0;
  logic [31:0] errAddr = '0;
  bit          finished = 1'b0;

  lbt_top i_lbt_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memGnt(memGnt), .memRspValid(memRspValid),
    .memRspData(memRspData), .memRspErr(memRspErr), .irqLegacy(irqLegacy),
    .msiReq(msiReq), .msiVec(msiVec)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) memGnt <= (($urandom % 4) != 0);

  always @(posedge clk) begin
    memRspValid <= memReq && memGnt;
    memRspErr   <= memReq && memGnt && errEn && (memAddr == errAddr);
    if (memReq && memGnt) begin
      accCnt++;
      memRspData <= mem[memAddr[13:2]];
      if (memWe) mem[memAddr[13:2]] <= memWdata;
    end
  end

  always @(negedge clk) if (rstN) begin
    if (irqLegacy) legCnt++;
    if (msiReq) begin msiCnt++; lastVec = msiVec; end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regWrEn = 1'b0; regAddr = a; #1 d = regRdData;
  endtask

  task automatic waitDone();
    logic [31:0] c;
    for (int n = 0; n < 4000; n++) begin
      regRd(3'd1, c);
      if (c == 0) return;
    end
    chk(1'b0, "R11 command never self-cleared", c, 0);
  endtask

  // hammer the command register while it reads nonzero; last write hits the finish cycle
  task automatic hammer(input logic [31:0] junk);
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); regWrEn = 1'b0; regAddr = 3'd1; #1;
      if (regRdData == 0) return;
      regWrData = junk; regWrEn = 1'b1;
    end
  endtask

  function automatic int nWords(input logic [31:0] sz);
    return int'((sz + 32'd3) >> 2);
  endfunction

  function automatic logic [31:0] irqBits(input logic [31:0] cmd);
    return (cmd[1] || cmd[0]) ? 32'h40 : 32'h0;
  endfunction

  task automatic checkIrq(input logic [31:0] cmd, input string tag);
    if (cmd[1]) begin
      chk(msiCnt == 1 && legCnt == 0, {tag, " R10 msi count"}, msiCnt, 1);
      chk(lastVec == cmd[7:2], {tag, " R10 msi vector"}, lastVec, cmd[7:2]);
    end else if (cmd[0])
      chk(legCnt == 1 && msiCnt == 0, {tag, " R10 legacy count"}, legCnt, 1);
    else
      chk(legCnt == 0 && msiCnt == 0, {tag, " R10 no irq"}, legCnt + msiCnt, 0);
  endtask

  task automatic startCmd(input logic [31:0] cmd);
    legCnt = 0; msiCnt = 0; accCnt = 0;
    regWr(3'd1, cmd);
  endtask

  initial begin
    logic [31:0] d, magic, src, dst, sz, cmd, sum, irqSel, expSts;
    logic [31:0] snap [0:15];
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      regRd(a[2:0], d);
      chk(d == 0, "R1 register after reset", d, 0);
    end
    chk(!memReq && !irqLegacy && !msiReq, "R1 outputs after reset", {memReq, irqLegacy, msiReq}, 0);

    // R2 scratch and read-only status
    for (int i = 0; i < 5; i++) begin
      magic = $urandom;
      regWr(3'd0, magic); regRd(3'd0, d);
      chk(d == magic, "R2 scratch readback", d, magic);
    end
    regWr(3'd2, 32'h1FF); regRd(3'd2, d);
    chk(d == 0, "R2 status write ignored", d, 0);

    // random operations: R4 R5 R6 R10 R11
    for (int it = 0; it < 30; it++) begin
      int op, nw;
      op  = $urandom % 3;
      sz  = 1 + ($urandom % 64);
      nw  = nWords(sz);
      src = WBASE + 4 * ($urandom % 1024);
      dst = WBASE + 32'h2000 + 4 * ($urandom % 1024);
      magic = $urandom;
      irqSel = $urandom % 3;
      cmd = (irqSel == 1 ? 32'h1 : irqSel == 2 ? (32'h2 | (($urandom % 64) << 2)) : 32'h0);
      regWr(3'd0, magic); regWr(3'd3, src); regWr(3'd4, dst); regWr(3'd5, sz);
      if (op == 0) begin
        sum = 0;
        for (int k = 0; k < nw; k++) sum ^= mem[(src - WBASE) / 4 + k];
        if ($urandom % 2) sum ^= 32'h1;
        regWr(3'd6, sum);
        cmd |= 32'h100;
        startCmd(cmd); waitDone();
        d = 0; for (int k = 0; k < nw; k++) d ^= mem[(src - WBASE) / 4 + k];
        expSts = ((d == sum) ? 32'h1 : 32'h2) | irqBits(cmd);
        regRd(3'd2, d);
        chk(d == expSts, "R5 read status", d, expSts);
      end else if (op == 1) begin
        cmd |= 32'h200;
        startCmd(cmd); waitDone();
        sum = 0;
        for (int k = 0; k < nw; k++) begin
          sum ^= magic ^ k;
          chk(mem[(dst - WBASE) / 4 + k] == (magic ^ k), "R4 written word", mem[(dst - WBASE) / 4 + k], magic ^ k);
        end
        regRd(3'd6, d);
        chk(d == sum, "R4 checksum", d, sum);
        expSts = 32'h4 | irqBits(cmd);
        regRd(3'd2, d);
        chk(d == expSts, "R4 write status", d, expSts);
      end else begin
        for (int k = 0; k < nw; k++) snap[k] = mem[(src - WBASE) / 4 + k];
        cmd |= 32'h400;
        startCmd(cmd); waitDone();
        for (int k = 0; k < nw; k++)
          chk(mem[(dst - WBASE) / 4 + k] == snap[k], "R6 copied word", mem[(dst - WBASE) / 4 + k], snap[k]);
        expSts = 32'h10 | irqBits(cmd);
        regRd(3'd2, d);
        chk(d == expSts, "R6 copy status", d, expSts);
      end
      checkIrq(cmd, "random");
      regRd(3'd1, d);
      chk(d == 0, "R11 command cleared", d, 0);
    end

    // R7 zero size with misaligned source
    regWr(3'd3, WBASE + 1); regWr(3'd5, 0);
    startCmd(32'h101); waitDone();
    regRd(3'd2, d);
    chk(d == 32'h41, "R7 zero size read ok", d, 32'h41);
    chk(accCnt == 0, "R7 no access on zero size", accCnt, 0);

    // R8 misaligned source on read
    regWr(3'd5, 8);
    startCmd(32'h100); waitDone();
    regRd(3'd2, d);
    chk(d == 32'h82, "R8 misaligned source", d, 32'h82);
    chk(accCnt == 0, "R8 no access misaligned", accCnt, 0);

    // R8 destination buffer crossing window end
    regWr(3'd4, WBASE + WBYTES - 4);
    startCmd(32'h200); waitDone();
    regRd(3'd2, d);
    chk(d == 32'h108, "R8 destination out of window", d, 32'h108);
    chk(accCnt == 0, "R8 no access out of window", accCnt, 0);

    // R8 copy with both bad
    startCmd(32'h400); waitDone();
    regRd(3'd2, d);
    chk(d == 32'h1A0, "R8 copy both bad", d, 32'h1A0);

    // R9 error response on second read word
    src = WBASE + 32'h100;
    regWr(3'd3, src); regWr(3'd5, 16);
    errEn = 1'b1; errAddr = src + 4;
    startCmd(32'h100); waitDone();
    errEn = 1'b0;
    regRd(3'd2, d);
    chk(d == 32'h2, "R9 error marks read failed", d, 32'h2);
    chk(accCnt == 2, "R9 stop after error", accCnt, 2);

    // R3 priority: write over copy, read over all
    dst = WBASE + 32'h3000; magic = 32'h5A5A_0F0F;
    regWr(3'd0, magic); regWr(3'd4, dst); regWr(3'd5, 8);
    startCmd(32'h600); waitDone();
    regRd(3'd2, d);
    chk(d == 32'h4, "R3 write beats copy", d, 32'h4);
    chk(mem[(dst - WBASE) / 4 + 1] == (magic ^ 1), "R3 write pattern", mem[(dst - WBASE) / 4 + 1], magic ^ 1);
    regWr(3'd6, 32'hDEAD_BEEF);
    startCmd(32'h700); waitDone();
    regRd(3'd2, d);
    chk(d == 32'h2 || d == 32'h1, "R3 read beats write and copy", d, 32'h2);

    // R12 config write while busy ignored
    src = WBASE + 32'h200; dst = WBASE + 32'h2400;
    regWr(3'd3, src); regWr(3'd4, dst); regWr(3'd5, 64);
    startCmd(32'h401);
    regWr(3'd3, WBASE + 32'h800);
    waitDone();
    regRd(3'd3, d);
    chk(d == src, "R12 source write while busy", d, src);

    // R12 command written on every busy cycle, including the finish cycle
    startCmd(32'h401);
    hammer(32'h202);
    @(negedge clk); regWrEn = 1'b0;
    regRd(3'd2, d);
    chk(d == 32'h50, "R12 hammered command ignored", d, 32'h50);
    checkIrq(32'h401, "hammer");
    regRd(3'd1, d);
    chk(d == 0, "R11 command clear after hammer", d, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule